// File: doc/BRIEF.md
# LDPC Early-Termination Iteration Controller

This controller runs next to a partially-parallel layered LDPC decoder and decides, while decoding is still in progress, when the current codeword should stop. On every accepted update beat the decoder presents one layer's worth of data:

- the new hard decisions of the columns it has just refreshed;
- the hard decisions those columns held before the refresh;
- a pass/fail bit for each parity row of that layer.

The controller keeps a per-layer clean map and a per-iteration flip tally. It ends the block in one of three ways:

- with success, once the syndrome is zero and no hard decision has moved for a full iteration;
- with abort, when the flip tally stays high for too many iterations in a row;
- plainly, when the iteration budget runs out.

A start pulse begins a new codeword. It also captures the run's configuration: the code rate, the iteration limit, the earliest iteration at which abort may fire, the flip threshold and the abort span. The code rate fixes how many layers form one iteration. Each decision is taken on the same clock edge that accepts the beat which makes it true, so the decoder loses no cycle waiting for the verdict.

Top module: `ldpc_iter_ctrl`

## Requirements
- R1: After reset, done, success and abort are low, iter_count is 0 and upd_ready is low. A start pulse clears done, success, abort and iter_count to 0 and raises upd_ready in the next cycle. A start pulse restarts a block that is still running.
- R2: upd_ready is high exactly while a block is running. Once done rises, done, success, abort and iter_count hold their values and beats offered with upd_valid are ignored until the next start.
- R3: A beat counts as clean when hd_new equals hd_old and every row_pass bit is 1. When the accepted beat leaves every layer of the selected rate with a clean latest visit, done and success are high in the cycle right after that beat's clock edge.
- R4: A hard-decision flip anywhere in an accepted beat invalidates every layer, even when all its rows pass. Success then needs one clean visit of every layer after the flip.
- R5: A beat with no flip but a failing row_pass bit marks only its own layer as not clean. Success waits until that layer is visited again with all rows passing.
- R6: rate_sel values 0 to 5 give 12, 10, 8, 6, 4 and 3 layers per iteration. Values 6 and 7 use the last entry, which is 3 layers. Layers are visited in order starting at 0 after start. iter_count increases by one on the accepted beat of the last layer.
- R7: The flip count of an iteration is the total number of bit positions where hd_new differs from hd_old over that iteration's beats. An iteration is counted as high when its number is at least min_iter and its flip count is at least flip_thresh. Any other completed iteration resets the run of high iterations. When abort_span consecutive high iterations have completed, done and abort rise and success stays low.
- R8: When iter_count reaches max_iter (max_iter at least 1) without convergence or abort, done rises with success and abort low.
- R9: Convergence takes priority. If the beat that completes convergence is also the last beat allowed by max_iter or by the abort rule, success is reported and abort stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a new codeword and captures the configuration |
| rate_sel | input | RATE_W | Code-rate select, which sets the layers per iteration |
| max_iter | input | ITER_W | Iteration budget |
| min_iter | input | ITER_W | Earliest iteration number that can count toward abort |
| flip_thresh | input | FLIP_W | Flip count per iteration at or above which the iteration is high |
| abort_span | input | SPAN_W | Number of consecutive high iterations that triggers abort |
| upd_valid | input | 1 | Update beat offered |
| upd_ready | output | 1 | Controller accepts beats (block running) |
| hd_new | input | COLS | Hard decisions after this layer's update |
| hd_old | input | COLS | Hard decisions of the same columns before the update |
| row_pass | input | ROWS | Parity result of each row in this layer (1 = satisfied) |
| done | output | 1 | Block finished |
| success | output | 1 | Finished with a valid codeword |
| abort | output | 1 | Finished as undecodable |
| iter_count | output | ITER_W | Completed iterations |

## Verification
The main stopping logic is driven with streams that are noisy for a set number of iterations and clean afterwards, and with streams that never settle. These are run at every code rate, including the out-of-range selects. The number of beats accepted before done tells a correct per-rate layer count and a zero-latency decision apart from an off-by-one. Never-settling streams are run with the flip threshold just at and just above the per-iteration flip total, and with min_iter delaying eligibility. These separate the abort rule from the budget stop. Directed streams place a flip on a beat whose rows all pass, and a parity failure without any flip. They show that a late flip invalidates every layer while a failing row blocks only its own layer.

// File: rtl/ldpc_itc_pkg.sv
package ldpc_itc_pkg;

   typedef enum logic [1:0] {
      ITC_IDLE = 2'd0,
      ITC_RUN  = 2'd1,
      ITC_DONE = 2'd2
   } itc_state_e;

   typedef enum logic [1:0] {
      END_NONE    = 2'd0,
      END_CONVERGE = 2'd1,
      END_ABORT   = 2'd2,
      END_BUDGET  = 2'd3
   } itc_end_e;

endpackage

// File: rtl/itc_flip_count.sv
module itc_flip_count #(
   parameter int COLS  = 16,
   parameter int CNT_W = $clog2(COLS + 1)
) (
   input  logic [COLS-1:0]  hd_new,
   input  logic [COLS-1:0]  hd_old,
   output logic [CNT_W-1:0] flips,
   output logic             any_flip
);

   logic [COLS-1:0] diff;

   genvar c;
   generate
      for (c = 0; c < COLS; c++) begin : g_diff
         assign diff[c] = hd_new[c] ^ hd_old[c];
      end
   endgenerate

   generate
      if (COLS == 1) begin : g_single
         assign flips = CNT_W'(diff[0]);
      end else begin : g_multi
         always_comb begin
            flips = '0;
            for (int i = 0; i < COLS; i++) begin
               flips = flips + CNT_W'(diff[i]);
            end
         end
      end
   endgenerate

   assign any_flip = |diff;

endmodule

// File: rtl/itc_parity_map.sv
module itc_parity_map #(
   parameter int MAX_LAYERS = 12,
   parameter int LAYER_W    = $clog2(MAX_LAYERS + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               upd,
   input  logic [LAYER_W-1:0] layer_idx,
   input  logic [LAYER_W-1:0] layers,
   input  logic               layer_pass,
   input  logic               any_flip,
   output logic               conv_now
);

   logic [MAX_LAYERS-1:0] clean_q;
   logic [MAX_LAYERS-1:0] clean_nx;
   logic [MAX_LAYERS-1:0] live_mask;

   always_comb begin
      clean_nx = clean_q;
      if (any_flip) begin
         clean_nx = '0;
      end else begin
         for (int i = 0; i < MAX_LAYERS; i++) begin
            if (layer_idx == LAYER_W'(i)) clean_nx[i] = layer_pass;
         end
      end
   end

   always_comb begin
      for (int i = 0; i < MAX_LAYERS; i++) begin
         live_mask[i] = (LAYER_W'(i) < layers);
      end
   end

   assign conv_now = upd && ((clean_nx & live_mask) == live_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clean_q <= '0;
      end else if (clear) begin
         clean_q <= '0;
      end else if (upd) begin
         clean_q <= clean_nx;
      end
   end

   // R4: a flipping beat can never complete convergence on that beat
   p_flip_no_conv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (upd && any_flip && !clear) |=> (clean_q == '0));

endmodule

// File: rtl/itc_iter_track.sv
module itc_iter_track #(
   parameter int MAX_LAYERS = 12,
   parameter int LAYER_W    = $clog2(MAX_LAYERS + 1),
   parameter int ITER_W     = 8,
   parameter int FLIP_W     = 16,
   parameter int SPAN_W     = 4,
   parameter int CNT_W      = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               upd,
   input  logic [LAYER_W-1:0] layers,
   input  logic [CNT_W-1:0]   beat_flips,
   input  logic [ITER_W-1:0]  min_iter,
   input  logic [ITER_W-1:0]  max_iter,
   input  logic [FLIP_W-1:0]  thresh,
   input  logic [SPAN_W-1:0]  span,
   output logic [LAYER_W-1:0] layer_idx,
   output logic [ITER_W-1:0]  iter_cnt,
   output logic               end_abort,
   output logic               end_budget
);

   logic [FLIP_W-1:0] iter_flips;
   logic [SPAN_W-1:0] high_run;
   logic [FLIP_W:0]   sum_wide;
   logic [FLIP_W-1:0] sum_sat;
   logic [ITER_W-1:0] iter_nx;
   logic [SPAN_W-1:0] run_nx;
   logic              last_layer;
   logic              high_iter;

   assign last_layer = (layer_idx == layers - LAYER_W'(1));
   assign sum_wide   = {1'b0, iter_flips} + (FLIP_W + 1)'(beat_flips);
   assign sum_sat    = sum_wide[FLIP_W] ? '1 : sum_wide[FLIP_W-1:0];
   assign iter_nx    = iter_cnt + ITER_W'(1);
   assign high_iter  = (iter_nx >= min_iter) && (sum_sat >= thresh);

   always_comb begin
      if (!high_iter)      run_nx = '0;
      else if (&high_run)  run_nx = high_run;
      else                 run_nx = high_run + SPAN_W'(1);
   end

   assign end_abort  = upd && last_layer && (span != '0) && (run_nx >= span);
   assign end_budget = upd && last_layer && (iter_nx >= max_iter);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         layer_idx  <= '0;
         iter_cnt   <= '0;
         iter_flips <= '0;
         high_run   <= '0;
      end else if (clear) begin
         layer_idx  <= '0;
         iter_cnt   <= '0;
         iter_flips <= '0;
         high_run   <= '0;
      end else if (upd) begin
         if (last_layer) begin
            layer_idx  <= '0;
            iter_cnt   <= iter_nx;
            iter_flips <= '0;
            high_run   <= run_nx;
         end else begin
            layer_idx  <= layer_idx + LAYER_W'(1);
            iter_flips <= sum_sat;
         end
      end
   end

   // R6: the layer pointer never walks past the selected rate's layer count
   p_layer_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (layers != '0) |-> (layer_idx < layers));

   // R6: iter_cnt moves only by one, and only on an accepted beat
   p_iter_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clear && !upd) |=> $stable(iter_cnt));

endmodule

// File: rtl/ldpc_iter_ctrl.sv
module ldpc_iter_ctrl
   import ldpc_itc_pkg::*;
#(
   parameter int COLS        = 16,
   parameter int ROWS        = 4,
   parameter int NUM_RATES   = 6,
   parameter int MAX_LAYERS  = 12,
   parameter int ITER_W      = 8,
   parameter int FLIP_W      = 16,
   parameter int SPAN_W      = 4,
   parameter int RATE_LAYERS [NUM_RATES] = '{12, 10, 8, 6, 4, 3},
   localparam int RATE_W     = (NUM_RATES > 1) ? $clog2(NUM_RATES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [RATE_W-1:0] rate_sel,
   input  logic [ITER_W-1:0] max_iter,
   input  logic [ITER_W-1:0] min_iter,
   input  logic [FLIP_W-1:0] flip_thresh,
   input  logic [SPAN_W-1:0] abort_span,
   input  logic              upd_valid,
   output logic              upd_ready,
   input  logic [COLS-1:0]   hd_new,
   input  logic [COLS-1:0]   hd_old,
   input  logic [ROWS-1:0]   row_pass,
   output logic              done,
   output logic              success,
   output logic              abort,
   output logic [ITER_W-1:0] iter_count
);

   localparam int LAYER_W = $clog2(MAX_LAYERS + 1);
   localparam int CNT_W   = $clog2(COLS + 1);

   // elaboration-time parameter checks
   generate
      if (COLS < 1 || ROWS < 1) begin : g_bad_width
         $error("ldpc_iter_ctrl: COLS and ROWS must be at least 1");
      end
      if (CNT_W > FLIP_W) begin : g_bad_flipw
         $error("ldpc_iter_ctrl: FLIP_W too narrow for one beat's flip count");
      end
      if (NUM_RATES < 1) begin : g_bad_rates
         $error("ldpc_iter_ctrl: NUM_RATES must be at least 1");
      end
      for (genvar r = 0; r < NUM_RATES; r++) begin : g_rate_chk
         if (RATE_LAYERS[r] < 1 || RATE_LAYERS[r] > MAX_LAYERS) begin : g_bad_layers
            $error("ldpc_iter_ctrl: RATE_LAYERS entry out of range");
         end
      end
   endgenerate

   itc_state_e        state_q;
   logic [LAYER_W-1:0] layers_q;
   logic [LAYER_W-1:0] sel_layers;
   logic [ITER_W-1:0]  max_q;
   logic [ITER_W-1:0]  min_q;
   logic [FLIP_W-1:0]  thr_q;
   logic [SPAN_W-1:0]  span_q;
   logic               done_q;
   logic               succ_q;
   logic               abort_q;

   logic               upd;
   logic [CNT_W-1:0]   beat_flips;
   logic               any_flip;
   logic               conv_now;
   logic               end_abort;
   logic               end_budget;
   logic [LAYER_W-1:0] layer_idx;
   logic [ITER_W-1:0]  iter_cnt;
   itc_end_e           verdict;

   always_comb begin
      sel_layers = LAYER_W'(RATE_LAYERS[NUM_RATES-1]);
      for (int r = 0; r < NUM_RATES; r++) begin
         if (rate_sel == RATE_W'(r)) sel_layers = LAYER_W'(RATE_LAYERS[r]);
      end
   end

   assign upd_ready = (state_q == ITC_RUN);
   assign upd       = upd_valid && upd_ready && !start;

   itc_flip_count #(
      .COLS  (COLS),
      .CNT_W (CNT_W)
   ) u_flips (
      .hd_new   (hd_new),
      .hd_old   (hd_old),
      .flips    (beat_flips),
      .any_flip (any_flip)
   );

   itc_parity_map #(
      .MAX_LAYERS (MAX_LAYERS),
      .LAYER_W    (LAYER_W)
   ) u_map (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start),
      .upd        (upd),
      .layer_idx  (layer_idx),
      .layers     (layers_q),
      .layer_pass (&row_pass),
      .any_flip   (any_flip),
      .conv_now   (conv_now)
   );

   itc_iter_track #(
      .MAX_LAYERS (MAX_LAYERS),
      .LAYER_W    (LAYER_W),
      .ITER_W     (ITER_W),
      .FLIP_W     (FLIP_W),
      .SPAN_W     (SPAN_W),
      .CNT_W      (CNT_W)
   ) u_iter (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start),
      .upd        (upd),
      .layers     (layers_q),
      .beat_flips (beat_flips),
      .min_iter   (min_q),
      .max_iter   (max_q),
      .thresh     (thr_q),
      .span       (span_q),
      .layer_idx  (layer_idx),
      .iter_cnt   (iter_cnt),
      .end_abort  (end_abort),
      .end_budget (end_budget)
   );

   // convergence outranks abort, abort outranks the budget stop
   always_comb begin
      if (conv_now)        verdict = END_CONVERGE;
      else if (end_abort)  verdict = END_ABORT;
      else if (end_budget) verdict = END_BUDGET;
      else                 verdict = END_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ITC_IDLE;
         layers_q <= LAYER_W'(RATE_LAYERS[0]);
         max_q    <= '0;
         min_q    <= '0;
         thr_q    <= '0;
         span_q   <= '0;
         done_q   <= 1'b0;
         succ_q   <= 1'b0;
         abort_q  <= 1'b0;
      end else if (start) begin
         state_q  <= ITC_RUN;
         layers_q <= sel_layers;
         max_q    <= max_iter;
         min_q    <= min_iter;
         thr_q    <= flip_thresh;
         span_q   <= abort_span;
         done_q   <= 1'b0;
         succ_q   <= 1'b0;
         abort_q  <= 1'b0;
      end else if (upd && verdict != END_NONE) begin
         state_q <= ITC_DONE;
         done_q  <= 1'b1;
         succ_q  <= (verdict == END_CONVERGE);
         abort_q <= (verdict == END_ABORT);
      end
   end

   assign done       = done_q;
   assign success    = succ_q;
   assign abort      = abort_q;
   assign iter_count = iter_cnt;

   // R1: a start pulse leaves a fresh, running block
   p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (!done && !success && !abort && iter_count == '0 && upd_ready));

   // R2: a finished block refuses beats
   p_ready_off_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !upd_ready);

   // R2: results freeze until the next start
   p_result_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(success) && $stable(abort) && $stable(iter_count)));

   // R3: success is only ever reported together with done
   p_success_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      success |-> done);

   // R7: abort is a terminal state exclusive with success
   p_abort_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> (done && !success));

   // R8: the iteration counter never exceeds the captured budget
   p_iter_le_max_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ITC_IDLE && max_q != '0) |-> (iter_count <= max_q));

endmodule

// File: tb/ldpc_iter_ctrl_test.sv
module ldpc_iter_ctrl_test;

   localparam int COLS   = 16;
   localparam int ROWS   = 4;
   localparam int ITER_W = 8;
   localparam int FLIP_W = 16;
   localparam int SPAN_W = 4;
   localparam int NVEC   = 9;

   // rate, max, min, thresh, span, noisy iters, flips/beat,
   // expected beats, success, abort, iter_count
   localparam int VEC [NVEC][11] = '{
      '{5, 20, 1, 100, 2,  2, 1,   9, 1, 0,  3},  // R3 settles after two noisy iterations
      '{4, 20, 1, 100, 2,  1, 2,   8, 1, 0,  2},  // R3 R6 four-layer rate
      '{3, 20, 2,  10, 2, 99, 3,  18, 0, 1,  3},  // R7 min_iter delays eligibility
      '{2,  4, 1, 100, 2, 99, 1,  32, 0, 0,  4},  // R8 budget stop
      '{0, 10, 1,  12, 3, 99, 1,  36, 0, 1,  3},  // R7 threshold reached exactly
      '{0, 10, 1,  13, 3, 99, 1, 120, 0, 0, 10},  // R7 R8 one below threshold
      '{1, 20, 1,   1, 1,  1, 1,  10, 0, 1,  1},  // R7 span of one
      '{5,  2, 1, 100, 2,  1, 1,   6, 1, 0,  2},  // R9 convergence on budget beat
      '{7, 20, 1, 100, 2,  0, 1,   3, 1, 0,  1}   // R6 out-of-range select
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [2:0]        rate_sel = '0;
   logic [ITER_W-1:0] max_iter = '0;
   logic [ITER_W-1:0] min_iter = '0;
   logic [FLIP_W-1:0] flip_thresh = '0;
   logic [SPAN_W-1:0] abort_span = '0;
   logic              upd_valid = 1'b0;
   logic              upd_ready;
   logic [COLS-1:0]   hd_new = '0;
   logic [COLS-1:0]   hd_old = '0;
   logic [ROWS-1:0]   row_pass = '0;
   logic              done;
   logic              success;
   logic              abort;
   logic [ITER_W-1:0] iter_count;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   ldpc_iter_ctrl uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .rate_sel    (rate_sel),
      .max_iter    (max_iter),
      .min_iter    (min_iter),
      .flip_thresh (flip_thresh),
      .abort_span  (abort_span),
      .upd_valid   (upd_valid),
      .upd_ready   (upd_ready),
      .hd_new      (hd_new),
      .hd_old      (hd_old),
      .row_pass    (row_pass),
      .done        (done),
      .success     (success),
      .abort       (abort),
      .iter_count  (iter_count)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int layers_of(input int rate);
      case (rate)
         0: return 12;
         1: return 10;
         2: return 8;
         3: return 6;
         4: return 4;
         default: return 3;
      endcase
   endfunction

   task automatic do_start(input int rate, input int mx, input int mn,
                           input int thr, input int span);
      @(negedge clk);
      rate_sel    = 3'(rate);
      max_iter    = ITER_W'(mx);
      min_iter    = ITER_W'(mn);
      flip_thresh = FLIP_W'(thr);
      abort_span  = SPAN_W'(span);
      start       = 1'b1;
      @(negedge clk);
      start       = 1'b0;
   endtask

   // drives one beat at a falling edge; returns at the next falling edge
   task automatic beat(input int f, input bit pass);
      hd_old    = COLS'($urandom);
      hd_new    = hd_old ^ ((COLS'(1) << f) - COLS'(1));
      row_pass  = pass ? '1 : '0;
      upd_valid = 1'b1;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset done", int'(done), 0);
      check("R1 reset ready", int'(upd_ready), 0);
      check("R1 reset iter", int'(iter_count), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NVEC; v++) begin
         int n;
         int lay;
         do_start(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
         lay = layers_of(VEC[v][0]);
         n = 0;
         while (!done && n < 500) begin
            if ((n / lay) < VEC[v][5]) beat(VEC[v][6], 1'b0);
            else                      beat(0, 1'b1);
            n++;
         end
         check($sformatf("R3/R6/R7/R8/R9 vec%0d beats", v), n, VEC[v][7]);
         check($sformatf("R3 R9 vec%0d success", v), int'(success), VEC[v][8]);
         check($sformatf("R7 vec%0d abort", v), int'(abort), VEC[v][9]);
         check($sformatf("R6 vec%0d iter_count", v), int'(iter_count), VEC[v][10]);
      end

      // R2: beats after done are ignored
      check("R2 ready low after done", int'(upd_ready), 0);
      beat(3, 1'b0);
      beat(3, 1'b0);
      beat(3, 1'b0);
      check("R2 done held", int'(done), 1);
      check("R2 success held", int'(success), 1);
      check("R2 iter held", int'(iter_count), 1);

      // R1: restart in the middle of a block
      do_start(0, 20, 1, 100, 2);
      beat(1, 1'b0);
      beat(1, 1'b0);
      do_start(0, 20, 1, 100, 2);
      check("R1 restart done", int'(done), 0);
      check("R1 restart iter", int'(iter_count), 0);
      check("R1 restart ready", int'(upd_ready), 1);

      // R4: late flip on a beat whose rows all pass
      do_start(5, 20, 1, 100, 2);
      beat(0, 1'b1);
      beat(0, 1'b1);
      beat(1, 1'b1);
      check("R4 no stop on flip beat", int'(done), 0);
      beat(0, 1'b1);
      beat(0, 1'b1);
      check("R4 still running", int'(done), 0);
      beat(0, 1'b1);
      check("R4 done after clean pass", int'(done), 1);
      check("R4 success", int'(success), 1);

      // R5: failing row without flip blocks only its own layer
      do_start(5, 20, 1, 100, 2);
      beat(0, 1'b1);
      beat(0, 1'b0);
      beat(0, 1'b1);
      beat(0, 1'b1);
      check("R5 waits for layer revisit", int'(done), 0);
      beat(0, 1'b1);
      check("R5 done on revisit", int'(done), 1);
      check("R5 success", int'(success), 1);
      check("R5 iter_count", int'(iter_count), 1);

      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule